// File: doc/BRIEF.md
# PWM Fault Protection Unit

This block watches for an external fault and puts a PWM timer's output pins into a safe state when one occurs. There are two fault sources: a digital interrupt pin and the output of an analog comparator. Each source passes through its own two-flop synchronizer, and a configuration bit selects one of them. The selected level can go through an optional noise filter, which changes its output only after four consecutive equal samples on the system clock. It then reaches an edge detector, which is set to react to either a rising or a falling transition.

While the unit is armed, a qualifying edge is a trip. A trip does four things in one clock:
- clears every compare-output mode bit, so each pin is driven by its port data bit instead of the PWM generator;
- disarms the unit;
- sets a sticky fault flag;
- raises the interrupt request if interrupts are enabled.

Software re-arms the unit through the configuration write and clears the flag with a write-one pulse.

Changing the source, the edge or the enable can itself produce a spurious event, so software is expected to clear the flag afterwards.

The control state machine has two states:
- `CTL_DISARMED`: the reset state.
- `CTL_ARMED`: the unit is watching for a fault.

It has three transitions:
- `T_ARM`, from `CTL_DISARMED` to `CTL_ARMED`, on a configuration write with the enable bit at 1.
- `T_OFF`, from `CTL_ARMED` to `CTL_DISARMED`, on a configuration write with the enable bit at 0.
- `T_TRIP`, from `CTL_ARMED` to `CTL_DISARMED`, on a qualifying edge. `T_TRIP` has priority over any write in the same cycle.

The noise filter has two states, `FLT_LOW` and `FLT_HIGH`. It moves between them only when the current sample and the three previous samples agree on the opposite level.

Top module: `pwm_fault_guard`

## Requirements
- R1: When `cfg_src_cmp_i` is 0 the fault source is `fault_pin_i`, and when it is 1 the source is `fault_cmp_i`. Transitions on the source that is not selected have no effect on the flag, the enable or the mode bits.
- R2: With the filter enabled, a change of the selected source that lasts fewer than four consecutive clock samples produces no trip. A change that lasts four or more samples does produce a trip.
- R3: Without the filter, a change applied between clock edges changes `flag_o`, `enable_o` and `mode_o` at the third rising edge that follows it. Enabling the filter moves this to the seventh rising edge, which is exactly four cycles later.
- R4: When `cfg_rise_i` is 0 only a falling edge (1 to 0) trips, and when it is 1 only a rising edge (0 to 1) trips. An edge of the other polarity, or any edge while `enable_o` is 0, has no effect.
- R5: On a trip all bits of `mode_o` become 0. `mode_o` holds one 2-bit field per channel, channel i at bits [2i+1:2i]. `pin_o[i]` equals `pwm_i[i]` when its field is nonzero and `port_i[i]` when its field is 00.
- R6: `enable_o` drops to 0 in the same cycle that `mode_o` clears. A configuration write with enable 1, or a mode write, in the same cycle as the trip is overridden, and the result is enable 0 and all mode bits 0.
- R7: A trip sets `flag_o`. `irq_o` is 1 exactly when `flag_o` is 1 and the interrupt enable written by the last configuration write is 1.
- R8: A one-cycle `flag_clr_i` pulse clears `flag_o` in the next cycle.
- R9: After reset, `enable_o`, `flag_o`, `irq_o` and `mode_o` are all 0, so every `pin_o` bit follows `port_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fault_pin_i | input | 1 | External interrupt pin fault source |
| fault_cmp_i | input | 1 | Analog comparator output fault source |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_enable_i | input | 1 | Enable value written (1 arms, 0 disarms) |
| cfg_filter_i | input | 1 | Noise filter enable value written |
| cfg_src_cmp_i | input | 1 | Source select value written (0 pin, 1 comparator) |
| cfg_rise_i | input | 1 | Edge select value written (0 falling, 1 rising) |
| cfg_irq_en_i | input | 1 | Interrupt enable value written |
| flag_clr_i | input | 1 | Write-one-to-clear pulse for the fault flag |
| mode_wr_i | input | 1 | Compare-output mode write strobe |
| mode_i | input | 2*CHANNELS | Compare-output mode value written |
| pwm_i | input | CHANNELS | PWM generator comparator outputs |
| port_i | input | CHANNELS | Port register data bits |
| pin_o | output | CHANNELS | Driven PWM pin levels |
| mode_o | output | 2*CHANNELS | Current compare-output mode bits |
| enable_o | output | 1 | Unit armed (1 in `CTL_ARMED`) |
| flag_o | output | 1 | Sticky fault flag |
| irq_o | output | 1 | Fault interrupt request |

## Verification
A control state machine stuck in the wrong state shows up at the first fault edge. If it is stuck armed, `enable_o` stays 1 and `mode_o` keeps its fields. If it is stuck disarmed, `flag_o` never rises. Either fault is visible at the third clock edge after the input change.

A filter state that is wrong, or a hold window with the wrong length, shifts the trip edge away from the seventh clock edge, or lets a three-cycle glitch trip the unit. A fault in the edge detector or the source mux appears as a trip for a polarity or a source that was not configured, or as a missing trip for one that was. That result can be read on `flag_o` within a dozen cycles.

// File: rtl/fpu_pkg.sv
package fpu_pkg;

    typedef enum logic {
        CTL_DISARMED = 1'b0,
        CTL_ARMED    = 1'b1
    } ctl_state_t;

    typedef enum logic {
        FLT_LOW  = 1'b0,
        FLT_HIGH = 1'b1
    } flt_state_t;

    typedef struct packed {
        logic filt_en;
        logic src_cmp;
        logic edge_rise;
        logic irq_en;
    } fpu_cfg_t;

endpackage

// File: rtl/fpu_sync.sv
module fpu_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/fpu_filter.sv
module fpu_filter
    import fpu_pkg::*;
#(
    parameter int TAPS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic din_i,
    output logic dout_o
);
    localparam int HIST = TAPS - 1;

    logic [HIST-1:0] hist_q;
    flt_state_t      state_q, state_d;
    logic            agree;
    logic            level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {hist_q[HIST-2:0], din_i};
    end

    assign agree = (hist_q == {HIST{din_i}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLT_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLT_LOW:  if (agree && din_i)  state_d = FLT_HIGH;
            FLT_HIGH: if (agree && !din_i) state_d = FLT_LOW;
            default:  state_d = FLT_LOW;
        endcase
    end

    assign level  = (state_q == FLT_HIGH);
    assign dout_o = enable_i ? level : din_i;

    // R2
    filter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level) |-> (($past(din_i) == level) && ($past(din_i, 2) == level)));
endmodule

// File: rtl/fpu_edge.sv
module fpu_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic x_i,
    input  logic rise_sel_i,
    output logic evt_o
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= x_i;
    end

    assign evt_o = rise_sel_i ? (x_i & ~prev_q) : (~x_i & prev_q);
endmodule

// File: rtl/fpu_ctrl.sv
module fpu_ctrl
    import fpu_pkg::*;
#(
    parameter int CHANNELS = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  evt_i,
    input  logic                  cfg_wr_i,
    input  logic                  cfg_enable_i,
    input  fpu_cfg_t              cfg_i,
    input  logic                  flag_clr_i,
    input  logic                  mode_wr_i,
    input  logic [2*CHANNELS-1:0] mode_i,
    output fpu_cfg_t              cfg_o,
    output logic [2*CHANNELS-1:0] mode_o,
    output logic                  enable_o,
    output logic                  flag_o
);
    ctl_state_t            state_q, state_d;
    logic                  trip;
    logic [2*CHANNELS-1:0] mode_q;
    logic                  flag_q;
    fpu_cfg_t              cfg_q;

    assign trip = evt_i && (state_q == CTL_ARMED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CTL_DISARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTL_DISARMED: if (cfg_wr_i && cfg_enable_i) state_d = CTL_ARMED;     // T_ARM
            CTL_ARMED: begin
                if (trip)                               state_d = CTL_DISARMED;  // T_TRIP
                else if (cfg_wr_i && !cfg_enable_i)     state_d = CTL_DISARMED;  // T_OFF
            end
            default: state_d = CTL_DISARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            flag_q <= 1'b0;
            cfg_q  <= '0;
        end else begin
            if (trip)           mode_q <= '0;
            else if (mode_wr_i) mode_q <= mode_i;
            if (trip)            flag_q <= 1'b1;
            else if (flag_clr_i) flag_q <= 1'b0;
            if (cfg_wr_i) cfg_q <= cfg_i;
        end
    end

    assign cfg_o    = cfg_q;
    assign mode_o   = mode_q;
    assign flag_o   = flag_q;
    assign enable_o = (state_q == CTL_ARMED);

    // R5
    mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> (mode_q == '0));
    // R6
    enable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> (state_q == CTL_DISARMED));
    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> flag_q);
    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !evt_i) |=> !flag_q);
    // R4
    no_trip_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == CTL_DISARMED) && !flag_q && !flag_clr_i) |=> !flag_q);
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
    import fpu_pkg::*;
#(
    parameter int CHANNELS    = 3,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_TAPS   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fault_pin_i,
    input  logic                  fault_cmp_i,
    input  logic                  cfg_wr_i,
    input  logic                  cfg_enable_i,
    input  logic                  cfg_filter_i,
    input  logic                  cfg_src_cmp_i,
    input  logic                  cfg_rise_i,
    input  logic                  cfg_irq_en_i,
    input  logic                  flag_clr_i,
    input  logic                  mode_wr_i,
    input  logic [2*CHANNELS-1:0] mode_i,
    input  logic [CHANNELS-1:0]   pwm_i,
    input  logic [CHANNELS-1:0]   port_i,
    output logic [CHANNELS-1:0]   pin_o,
    output logic [2*CHANNELS-1:0] mode_o,
    output logic                  enable_o,
    output logic                  flag_o,
    output logic                  irq_o
);
    localparam int NSRC = 2;

    logic [NSRC-1:0] raw_src;
    logic [NSRC-1:0] sync_src;
    logic            sel_level;
    logic            filt_level;
    logic            evt;
    fpu_cfg_t        cfg_wr_val;
    fpu_cfg_t        cfg_cur;
    logic [2*CHANNELS-1:0] mode_cur;

    assign raw_src = {fault_cmp_i, fault_pin_i};

    for (genvar s = 0; s < NSRC; s++) begin : g_sync
        fpu_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (raw_src[s]),
            .q_o   (sync_src[s])
        );
    end

    assign sel_level = cfg_cur.src_cmp ? sync_src[1] : sync_src[0];

    fpu_filter #(.TAPS(FILT_TAPS)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (cfg_cur.filt_en),
        .din_i    (sel_level),
        .dout_o   (filt_level)
    );

    fpu_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .x_i        (filt_level),
        .rise_sel_i (cfg_cur.edge_rise),
        .evt_o      (evt)
    );

    assign cfg_wr_val = '{filt_en: cfg_filter_i, src_cmp: cfg_src_cmp_i,
                          edge_rise: cfg_rise_i, irq_en: cfg_irq_en_i};

    fpu_ctrl #(.CHANNELS(CHANNELS)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_i        (evt),
        .cfg_wr_i     (cfg_wr_i),
        .cfg_enable_i (cfg_enable_i),
        .cfg_i        (cfg_wr_val),
        .flag_clr_i   (flag_clr_i),
        .mode_wr_i    (mode_wr_i),
        .mode_i       (mode_i),
        .cfg_o        (cfg_cur),
        .mode_o       (mode_cur),
        .enable_o     (enable_o),
        .flag_o       (flag_o)
    );

    for (genvar c = 0; c < CHANNELS; c++) begin : g_pin
        assign pin_o[c] = (mode_cur[2*c +: 2] != 2'b00) ? pwm_i[c] : port_i[c];
    end

    assign mode_o = mode_cur;
    assign irq_o  = flag_o & cfg_cur.irq_en;

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!flag_o && !enable_o && (mode_cur == '0)));
endmodule

// File: tb/pwm_fault_guard_tb.sv
`timescale 1ns/1ps
module pwm_fault_guard_tb;
    localparam int CH = 3;
    localparam logic [2*CH-1:0] ALL_ON = '1;

    // vector: [7]src [6]rise [5]filt [4]pin0 [3]pin1 [2]cmp0 [1]cmp1 [0]expect trip
    localparam int NV = 9;
    localparam logic [7:0] VECS [NV] = '{
        8'b00010111, 8'b00001110, 8'b01001111, 8'b00011100, 8'b10011101,
        8'b11010011, 8'b11001000, 8'b00110111, 8'b11111011
    };

    logic clk = 1'b0;
    logic rst_n;
    logic fault_pin, fault_cmp;
    logic cfg_wr, cfg_en, cfg_filt, cfg_src, cfg_rise, cfg_irq;
    logic flag_clr, mode_wr;
    logic [2*CH-1:0] mode_in;
    logic [CH-1:0] pwm, port;
    logic [CH-1:0] pin;
    logic [2*CH-1:0] mode;
    logic enable, flag, irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pwm_fault_guard #(.CHANNELS(CH)) u_dut (
        .clk(clk), .rst_n(rst_n), .fault_pin_i(fault_pin), .fault_cmp_i(fault_cmp),
        .cfg_wr_i(cfg_wr), .cfg_enable_i(cfg_en), .cfg_filter_i(cfg_filt),
        .cfg_src_cmp_i(cfg_src), .cfg_rise_i(cfg_rise), .cfg_irq_en_i(cfg_irq),
        .flag_clr_i(flag_clr), .mode_wr_i(mode_wr), .mode_i(mode_in),
        .pwm_i(pwm), .port_i(port), .pin_o(pin), .mode_o(mode),
        .enable_o(enable), .flag_o(flag), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(input logic en, input logic filt, input logic src,
                             input logic rise, input logic irqen);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_en = en; cfg_filt = filt; cfg_src = src;
        cfg_rise = rise; cfg_irq = irqen;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic mode_write(input logic [2*CH-1:0] m);
        @(negedge clk);
        mode_wr = 1'b1; mode_in = m;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic flag_clear();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic arm(input logic filt, input logic src, input logic rise, input logic irqen);
        cfg_write(1'b0, filt, src, rise, irqen);
        idle(12);
        flag_clear();
        mode_write(ALL_ON);
        cfg_write(1'b1, filt, src, rise, irqen);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        fault_pin = 1'b1; fault_cmp = 1'b1;
        cfg_wr = 0; cfg_en = 0; cfg_filt = 0; cfg_src = 0; cfg_rise = 0; cfg_irq = 0;
        flag_clr = 0; mode_wr = 0; mode_in = '0;
        pwm = 3'b101; port = 3'b010;
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R9 reset state
        chk("R9 enable", enable, 0);
        chk("R9 flag", flag, 0);
        chk("R9 irq", irq, 0);
        chk("R9 mode", mode, 0);
        chk("R9 pins", pin, port);

        // vector table: R1 source select, R4 edge select, R2 filter pass
        for (int v = 0; v < NV; v++) begin
            logic [7:0] w;
            w = VECS[v];
            fault_pin = w[4]; fault_cmp = w[2];
            arm(w[5], w[7], w[6], 1'b0);
            @(negedge clk);
            fault_pin = w[3]; fault_cmp = w[1];
            idle(12);
            chk($sformatf("R1/R4 vec%0d flag", v), flag, w[0]);
            chk($sformatf("R6 vec%0d enable", v), enable, !w[0]);
            chk($sformatf("R5 vec%0d mode", v), mode, w[0] ? '0 : ALL_ON);
            fault_pin = 1'b1; fault_cmp = 1'b1;
            idle(10);
        end

        // R3 latency without filter, R5 pins, R7 irq
        arm(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R5 pins armed", pin, pwm);
        fault_pin = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R3 nofilt early flag", flag, 0);
        chk("R3 nofilt early enable", enable, 1);
        @(posedge clk);
        @(negedge clk);
        chk("R3 nofilt flag", flag, 1);
        chk("R6 same-cycle enable", enable, 0);
        chk("R5 same-cycle mode", mode, 0);
        chk("R5 pins tripped", pin, port);
        chk("R7 irq on", irq, 1);
        // R8 clear
        flag_clear();
        chk("R8 flag cleared", flag, 0);
        chk("R7 irq cleared", irq, 0);
        fault_pin = 1'b1;
        idle(10);

        // R7 flag without irq enable
        arm(1'b0, 1'b0, 1'b0, 1'b0);
        fault_pin = 1'b0;
        idle(8);
        chk("R7 flag irq off", flag, 1);
        chk("R7 irq masked", irq, 0);
        fault_pin = 1'b1;
        idle(10);

        // R5 mixed mode fields: channel 1 field 00 uses port
        mode_write(6'b110011);
        chk("R5 mixed pins", pin, {pwm[2], port[1], pwm[0]});

        // R3 latency with filter
        arm(1'b1, 1'b0, 1'b0, 1'b0);
        fault_pin = 1'b0;
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk("R3 filt early flag", flag, 0);
        @(posedge clk);
        @(negedge clk);
        chk("R3 filt flag", flag, 1);
        fault_pin = 1'b1;
        idle(12);

        // R2 three-cycle glitch rejected with filter
        arm(1'b1, 1'b0, 1'b0, 1'b0);
        fault_pin = 1'b0;
        idle(3);
        fault_pin = 1'b1;
        idle(12);
        chk("R2 glitch flag", flag, 0);
        chk("R2 glitch enable", enable, 1);
        // R2 four-cycle low accepted
        fault_pin = 1'b0;
        idle(4);
        fault_pin = 1'b1;
        idle(12);
        chk("R2 four-sample flag", flag, 1);
        idle(10);

        // R2 single-cycle pulse trips without filter
        arm(1'b0, 1'b0, 1'b0, 1'b0);
        fault_pin = 1'b0;
        idle(1);
        fault_pin = 1'b1;
        idle(8);
        chk("R2 nofilt pulse flag", flag, 1);
        idle(10);

        // R4 disarmed: edge ignored
        cfg_write(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        flag_clear();
        mode_write(ALL_ON);
        fault_pin = 1'b0;
        idle(10);
        chk("R4 disarmed flag", flag, 0);
        chk("R4 disarmed mode", mode, ALL_ON);
        fault_pin = 1'b1;
        idle(10);

        // R6 coincident writes lose to the trip
        arm(1'b0, 1'b0, 1'b0, 1'b0);
        fault_pin = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_en = 1'b1; mode_wr = 1'b1; mode_in = ALL_ON;
        @(negedge clk);
        cfg_wr = 1'b0; mode_wr = 1'b0;
        chk("R6 coincide enable", enable, 0);
        chk("R6 coincide mode", mode, 0);
        chk("R6 coincide flag", flag, 1);
        fault_pin = 1'b1;
        idle(5);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule